// File: doc/BRIEF.md
# Multi-Core Shared Pin Combiner

This block lets several independent processor cores share one bank of bidirectional I/O pins. Each core keeps its own private direction vector and its own private output vector. A core updates them through a dedicated write port. A per-core run flag tells the block whether that core is executing. The block merges every core's contribution into one output-enable vector and one output-level vector for the pad drivers. It also hands the synchronised pin levels back to all cores.

The merge is a wired-OR. A pin is enabled when any core marks it as an output. The pin is driven high when any core that marks it as an output also holds a 1 in its output bit for that pin. An output bit whose direction bit is 0 is masked away before the OR, so it has no effect.

The run flag controls the clearing of registers. Whenever a core is not running, its two vectors are forced to zero. A stopped core therefore cannot hold a pin in any state, and a core always restarts from a clean, all-input state. Core sequencing, program execution and pad electrical behaviour are outside this block.

Top module: `core_pin_merge`

## Requirements
- R1: Each core has a private direction vector and a private output vector. They are written only through that core's port: `wrEn[c]` with `wrSel[c]`=0 loads direction, `wrSel[c]`=1 loads output, and the data comes from bits `c*NPIN +: NPIN` of `wrData`. A write by one core never changes another core's vectors.
- R2: When `coreRun[c]` is sampled low at a clock edge, both vectors of core c are zero after that edge, whatever was written before.
- R3: A core that is restarted after a stop begins with both vectors at zero.
- R4: `padOe[p]` is 1 exactly when at least one core has direction bit p set.
- R5: `padOut[p]` is 1 exactly when at least one core has both direction bit p and output bit p set. Otherwise it is 0, including when the pin is not enabled.
- R6: An output bit held by a core whose direction bit for that pin is 0 has no effect on `padOe` or `padOut`.
- R7: When `coreRun[c]` is low, a write by core c is discarded. This holds even when the write arrives in the same cycle as the stop.
- R8: A write sampled at clock edge E changes the core's vectors at E. `padOe` and `padOut` reflect the new vectors from edge E+1, and hold their previous value between E and E+1.
- R9: `pinLevel` equals `padIn` delayed by exactly two clock edges. The same vector is presented to every core.
- R10: Synchronous reset `rst` clears every core's vectors and the synchroniser, so `padOe`, `padOut` and `pinLevel` are all zero after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| coreRun | input | NCORE | Per-core run flag (1 = executing) |
| wrEn | input | NCORE | Per-core register write strobe |
| wrSel | input | NCORE | Per-core register select: 0 direction, 1 output |
| wrData | input | NCORE*NPIN | Per-core write data, core c in bits c*NPIN +: NPIN |
| padIn | input | NPIN | Raw pin levels from the pads |
| padOe | output | NPIN | Registered merged output enable |
| padOut | output | NPIN | Registered merged output level |
| pinLevel | output | NPIN | Synchronised pin levels for all cores |

## Verification
The bench uses three cores and four pins. It walks every combination of direction and output bit across the three cores on every pin, so the masking of output by direction and the two separate OR trees are all exercised. A design that ORed raw output bits would show a high on a pin nobody enables. A design that ORed only one core would miss two-core overlaps.

Directed cases cover the following:
- A stop that coincides with a write. A design that let the write win would leave a stuck output after the core stops.
- A restart followed by an output-only write. A design that did not clear on stop would wrongly re-enable the pin.
- The exact one-edge pad latency and the two-edge read latency. An extra or missing register stage shows up as a miscompare at the sampled cycle.

// File: rtl/core_pin_pkg.sv
package core_pin_pkg;

  // Per-core strobes from control to datapath.
  typedef struct packed {
    logic clr;    // force both vectors to zero
    logic dirLd;  // load direction vector
    logic outLd;  // load output vector
  } coreStrobe_t;

endpackage

// File: rtl/core_pin_ctrl.sv
module core_pin_ctrl
  import core_pin_pkg::*;
#(
  parameter int NCORE = 8
) (
  input  logic [NCORE-1:0] coreRun,
  input  logic [NCORE-1:0] wrEn,
  input  logic [NCORE-1:0] wrSel,
  output coreStrobe_t [NCORE-1:0] stb
);

  // A stopped core is cleared and its writes are dropped (stop wins).
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    always_comb begin
      stb[c].clr   = ~coreRun[c];
      stb[c].dirLd = coreRun[c] & wrEn[c] & ~wrSel[c];
      stb[c].outLd = coreRun[c] & wrEn[c] &  wrSel[c];
    end
  end

endmodule

// File: rtl/core_pin_datapath.sv
module core_pin_datapath
  import core_pin_pkg::*;
#(
  parameter int NCORE     = 8,
  parameter int NPIN      = 32,
  parameter int SYNCSTAGE = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  coreStrobe_t [NCORE-1:0] stb,
  input  logic [NCORE*NPIN-1:0]   wrData,
  input  logic [NPIN-1:0]         padIn,
  output logic [NPIN-1:0]         padOe,
  output logic [NPIN-1:0]         padOut,
  output logic [NPIN-1:0]         pinLevel
);

  localparam int DATAW = NCORE * NPIN;

  logic [DATAW-1:0] dirFlat;
  logic [DATAW-1:0] outFlat;

  // Private register pair per core.
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NPIN-1:0] dirReg;
    logic [NPIN-1:0] outReg;

    always_ff @(posedge clk) begin
      if (rst || stb[c].clr) begin
        dirReg <= '0;
        outReg <= '0;
      end else begin
        if (stb[c].dirLd) dirReg <= wrData[c*NPIN +: NPIN];
        if (stb[c].outLd) outReg <= wrData[c*NPIN +: NPIN];
      end
    end

    assign dirFlat[c*NPIN +: NPIN] = dirReg;
    assign outFlat[c*NPIN +: NPIN] = outReg;
  end

  // Wired-OR merge with per-core direction masking.
  logic [NPIN-1:0] oeMerge;
  logic [NPIN-1:0] valMerge;

  always_comb begin
    oeMerge  = '0;
    valMerge = '0;
    for (int c = 0; c < NCORE; c++) begin
      oeMerge  = oeMerge  | dirFlat[c*NPIN +: NPIN];
      valMerge = valMerge | (dirFlat[c*NPIN +: NPIN] & outFlat[c*NPIN +: NPIN]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      padOe  <= '0;
      padOut <= '0;
    end else begin
      padOe  <= oeMerge;
      padOut <= valMerge;
    end
  end

  // Read-back synchroniser chain.
  logic [NPIN-1:0] syncChain [SYNCSTAGE];

  for (genvar s = 0; s < SYNCSTAGE; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) syncChain[s] <= '0;
      else if (s == 0) syncChain[s] <= padIn;
      else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
    end
  end

  assign pinLevel = syncChain[SYNCSTAGE-1];

endmodule

// File: rtl/core_pin_merge.sv
module core_pin_merge
  import core_pin_pkg::*;
#(
  parameter int NCORE = 8,
  parameter int NPIN  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCORE-1:0]      coreRun,
  input  logic [NCORE-1:0]      wrEn,
  input  logic [NCORE-1:0]      wrSel,
  input  logic [NCORE*NPIN-1:0] wrData,
  input  logic [NPIN-1:0]       padIn,
  output logic [NPIN-1:0]       padOe,
  output logic [NPIN-1:0]       padOut,
  output logic [NPIN-1:0]       pinLevel
);

  coreStrobe_t [NCORE-1:0] stb;

  core_pin_ctrl #(.NCORE(NCORE)) u_ctrl (
    .coreRun(coreRun),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .stb    (stb)
  );

  core_pin_datapath #(.NCORE(NCORE), .NPIN(NPIN), .SYNCSTAGE(2)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrData  (wrData),
    .padIn   (padIn),
    .padOe   (padOe),
    .padOut  (padOut),
    .pinLevel(pinLevel)
  );

endmodule

// File: rtl/core_pin_merge_chk.sv
module core_pin_merge_chk #(
  parameter int NCORE = 8,
  parameter int NPIN  = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCORE-1:0]      coreRun,
  input logic [NCORE-1:0]      wrEn,
  input logic [NPIN-1:0]       padIn,
  input logic [NPIN-1:0]       padOe,
  input logic [NPIN-1:0]       padOut,
  input logic [NPIN-1:0]       pinLevel
);

  logic       prevRst = 1'b0;
  logic [1:0] liveCnt = 2'd0;

  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (rst) liveCnt <= 2'd0;
    else if (liveCnt != 2'd2) liveCnt <= liveCnt + 2'd1;
  end

  // R5: a pin never goes high unless it is enabled
  a_r5_high_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (padOut & ~padOe) == '0);

  // R2: with every core stopped, nothing is enabled two edges later
  a_r2_stop_releases_pins: assert property (@(posedge clk) disable iff (rst)
    (coreRun == '0) |=> ##1 (padOe == '0));

  // R7: a write from a core that is stopped cannot enable a pin
  a_r7_stopped_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (coreRun == '0 && wrEn != '0) |=> ##1 (padOe == '0));

  // R9: read path is exactly two edges deep
  a_r9_sync_depth: assert property (@(posedge clk) disable iff (rst)
    (liveCnt == 2'd2) |-> (pinLevel == $past(padIn, 2)));

  // R10: after a reset edge all outputs are zero
  a_r10_reset_idle: assert property (@(posedge clk)
    prevRst |-> (padOe == '0 && padOut == '0 && pinLevel == '0));

endmodule

bind core_pin_merge core_pin_merge_chk #(.NCORE(NCORE), .NPIN(NPIN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .coreRun (coreRun),
  .wrEn    (wrEn),
  .padIn   (padIn),
  .padOe   (padOe),
  .padOut  (padOut),
  .pinLevel(pinLevel)
);

// File: tb/core_pin_merge_test.sv
module core_pin_merge_test;

  localparam int NC = 3;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [NC-1:0] coreRun;
  logic [NC-1:0] wrEn;
  logic [NC-1:0] wrSel;
  logic [NC*NP-1:0] wrData;
  logic [NP-1:0] padIn;
  logic [NP-1:0] padOe;
  logic [NP-1:0] padOut;
  logic [NP-1:0] pinLevel;

  int checks = 0;
  int errs   = 0;

  logic [NP-1:0] mDir [NC];
  logic [NP-1:0] mOut [NC];

  always #2.5 clk = ~clk;

  core_pin_merge #(.NCORE(NC), .NPIN(NP)) uut (
    .clk(clk), .rst(rst), .coreRun(coreRun), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .padIn(padIn), .padOe(padOe), .padOut(padOut),
    .pinLevel(pinLevel)
  );

  task automatic chk(input string req, input logic [NP-1:0] act,
                     input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  endtask

  // One write cycle: drive at negedge, strobes removed at the next negedge.
  task automatic wrCycle(input logic [NC-1:0] en, input logic [NC-1:0] sel,
                         input logic [NC*NP-1:0] data);
    @(negedge clk);
    wrEn   = en;
    wrSel  = sel;
    wrData = data;
    @(negedge clk);
    wrEn   = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NP-1:0] expOe();
    logic [NP-1:0] r = '0;
    for (int c = 0; c < NC; c++) r |= mDir[c];
    return r;
  endfunction

  function automatic logic [NP-1:0] expOut();
    logic [NP-1:0] r = '0;
    for (int c = 0; c < NC; c++) r |= mDir[c] & mOut[c];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    rst = 1'b1; coreRun = '1; wrEn = '0; wrSel = '0; wrData = '0; padIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 padOe after reset", padOe, '0);
    chk("R10 padOut after reset", padOut, '0);
    chk("R10 pinLevel after reset", pinLevel, '0);
    rst = 1'b0;

    // R4 R5 R6 sweep: every (dir,out) combination of three cores on every pin.
    for (int i = 0; i < 64; i++) begin
      logic [NC*NP-1:0] dv;
      logic [NC*NP-1:0] ov;
      for (int c = 0; c < NC; c++) begin
        mDir[c] = '0;
        mOut[c] = '0;
      end
      for (int p = 0; p < NP; p++) begin
        int combo;
        combo = (i + p * 21) % 64;
        for (int c = 0; c < NC; c++) begin
          mDir[c][p] = combo[2*c];
          mOut[c][p] = combo[2*c+1];
        end
      end
      for (int c = 0; c < NC; c++) begin
        dv[c*NP +: NP] = mDir[c];
        ov[c*NP +: NP] = mOut[c];
      end
      @(negedge clk);
      wrEn = '1; wrSel = '0; wrData = dv;
      @(negedge clk);
      wrSel = '1; wrData = ov;
      @(negedge clk);
      wrEn = '0;
      @(negedge clk);
      chk("R4 merged enable", padOe, expOe());
      chk("R5 R6 merged level", padOut, expOut());
    end

    // Clear everything.
    wrCycle('1, '0, '0);
    wrCycle('1, '1, '0);
    settle(2);
    chk("R4 cleared", padOe, '0);

    // R8 latency: write core0 direction, check before and after the pad edge.
    @(negedge clk);
    wrEn = 3'b001; wrSel = '0; wrData = {8'h00, 4'b0101};
    @(negedge clk);
    wrEn = '0;
    chk("R8 pads unchanged one edge after write", padOe, 4'b0000);
    @(negedge clk);
    chk("R8 pads updated next edge", padOe, 4'b0101);

    // R1 privacy: core1 writes, core0 keeps its own vector.
    wrCycle(3'b010, '0, {4'h0, 4'b1010, 4'hF});
    settle(1);
    chk("R1 core1 joins core0", padOe, 4'b1111);
    wrCycle(3'b010, '0, {4'h0, 4'b0000, 4'hF});
    settle(1);
    chk("R1 core0 kept after core1 write", padOe, 4'b0101);

    // R2 stop clears core0.
    wrCycle(3'b001, 3'b001, {8'h00, 4'b0101});
    settle(1);
    chk("R2 core0 driving high before stop", padOut, 4'b0101);
    @(negedge clk); coreRun[0] = 1'b0;
    @(negedge clk); coreRun[0] = 1'b1;
    settle(1);
    chk("R2 enable released after stop", padOe, 4'b0000);
    chk("R2 level released after stop", padOut, 4'b0000);

    // R3 restart from zero: output-only write must not enable a pin.
    wrCycle(3'b001, 3'b001, {8'h00, 4'b1111});
    settle(1);
    chk("R3 direction zero after restart", padOe, 4'b0000);
    chk("R3 no level after restart", padOut, 4'b0000);
    wrCycle(3'b001, 3'b000, {8'h00, 4'b0011});
    settle(1);
    chk("R3 new direction honoured", padOe, 4'b0011);
    chk("R3 new output honoured", padOut, 4'b0011);

    // R7 stop and write in the same cycle: stop wins.
    @(negedge clk);
    coreRun[2] = 1'b0; wrEn = 3'b100; wrSel = 3'b000; wrData = {4'b1100, 8'h00};
    @(negedge clk);
    wrEn = '0; coreRun[2] = 1'b1;
    settle(2);
    chk("R7 write dropped on stop cycle", padOe, 4'b0011);
    // Writes while held stopped are dropped.
    @(negedge clk); coreRun[2] = 1'b0;
    wrCycle(3'b100, 3'b000, {4'b1000, 8'h00});
    wrCycle(3'b100, 3'b100, {4'b1000, 8'h00});
    @(negedge clk); coreRun[2] = 1'b1;
    settle(2);
    chk("R7 stopped-core enable dropped", padOe, 4'b0011);
    chk("R7 stopped-core level dropped", padOut, 4'b0011);

    // R9 read synchroniser depth.
    @(negedge clk); padIn = 4'b1011;
    @(negedge clk);
    chk("R9 pin level after one edge", pinLevel, 4'b0000);
    @(negedge clk);
    chk("R9 pin level after two edges", pinLevel, 4'b1011);
    @(negedge clk); padIn = 4'b0100;
    settle(2);
    chk("R9 second pattern", pinLevel, 4'b0100);

    // R10 reset mid-run.
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R10 enable cleared by reset", padOe, '0);
    chk("R10 level cleared by reset", pinLevel, '0);
    rst = 1'b0;
    settle(2);
    chk("R10 core vectors cleared by reset", padOe, '0);

    finishRun();
  end

endmodule